// File: doc/BRIEF.md
# Hub Port Status Serial Frame Generator

This block collects the status of eight twisted-pair hub ports and of the shared medium. It sends that status as three serial streams of 8-bit frames. Each stream has its own data pin. All three streams share one shift clock and one latch strobe. The intended receiver is an external shift register and latch per stream, which turn each frame back into eight parallel signals for indicator lamps.

The first stream carries the link state of each port. A received packet lights the port's bit for a fixed hold time and then forces it dark for a fixed rest time, so that even short packets stay visible. The second stream carries the partition state of each port. The third stream carries a bar-graph (thermometer) code of how busy the medium was during the last measurement window.

The shift clock runs at half the system clock rate. Durations that are given in milliseconds are counted from a millisecond tick input, so a test can use a short tick period.

Top module: `hubled_serializer`

## Requirements
- R1: Each stream sends an 8-bit frame with bit 7 first and bit 0 last. In the link and partition frames, bit n belongs to port n.
- R2: `sclk` toggles on every system clock cycle. The data pins change only in the cycle where `sclk` falls.
- R3: `latchStb` is high for exactly one bit period, which is the period of bit 0 of every frame. Consecutive strobe periods are exactly 8 `sclk` rising edges apart. The `sclk` rising edge that occurs while the strobe is high completes the frame.
- R4: A port's link bit is 1 when the port's link is failed (`linkOk[n]=0`). It is 0 when the link passes and no receive hold is active.
- R5: While a port's receive stretcher is idle, `rxAct[n]=1` drives the link bit high for `HI_MS` ticks. The link bit is then low for `LO_MS` ticks, and any `rxAct` during that rest time is ignored.
- R6: A port's partition bit is 0 when `portPart[n]=1` (partitioned) and 1 otherwise.
- R7: Traffic bit i is 0 when the busy share strictly exceeds the i-th threshold, with thresholds 1%, 6.25%, 12.5%, 25%, 37.5%, 50%, 62.5% and 87.5% for i = 0 to 7.
- R8: The busy share is counted once per bit period over a window of 2^`WIN_LOG2` bit periods. The traffic code changes only at the end of a window and reads 8'hFF before the first window ends.
- R9: During reset, `sclk`, `latchStb` and all three data pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the shift clock rate |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-cycle pulse per millisecond |
| linkOk | input | 8 | Per-port link pass flag |
| rxAct | input | 8 | Per-port receive activity flag |
| portPart | input | 8 | Per-port partitioned flag |
| mediumBusy | input | 1 | Shared medium carries traffic |
| sclk | output | 1 | Shift clock for the external registers |
| latchStb | output | 1 | Frame latch strobe |
| linkSer | output | 1 | Serial link/receive frame |
| partSer | output | 1 | Serial partition frame |
| trafSer | output | 1 | Serial traffic bar-graph frame |

## Verification
The embedded properties check the following on every cycle:
- The data pins stay still except at a falling edge of `sclk`.
- The strobe lasts exactly one bit period.
- A partition frame loads the flags present at its load edge.
- The traffic code always has a valid bar-graph shape.
- The busy counter never passes the window length.
- A receive hold does not end between ticks.

Only the bench scenarios can show the following:
- The decoded frame contents and the bit order.
- The exact threshold boundaries at 12.5%, 50% and 87.5%.
- The timed hold and rest sequence, including a packet that is ignored during the rest time.
- The all-ones traffic code before the first window ends.

// File: rtl/hubled_pkg.sv
package hubled_pkg;
  localparam int FRAME_W = 8;
  localparam int IDX_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic load;     // start a new frame at this sclk fall
    logic shift;    // advance to next bit at this sclk fall
    logic bitTick;  // one per bit period
    logic winEnd;   // last bit period of a utilization window
  } hubStrobe_t;
endpackage

// File: rtl/hubled_stretch.sv
module hubled_stretch #(
  parameter int HI_MS = 78,
  parameter int LO_MS = 52
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic rxAct,
  output logic hold
);
  localparam int MAX_MS = (HI_MS > LO_MS) ? HI_MS : LO_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} stretchState_t;
  stretchState_t state;
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (rxAct) begin
          state   <= S_HI;
          tickCnt <= '0;
        end
        S_HI: if (msTick) begin
          if (tickCnt == CNT_W'(HI_MS - 1)) begin
            state   <= S_LO;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_LO: if (msTick) begin
          if (tickCnt == CNT_W'(LO_MS - 1)) begin
            state   <= S_IDLE;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign hold = (state == S_HI);

  // R5: a hold never ends without a tick
  a_r5_hold_until_tick: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HI && !msTick) |=> (state == S_HI));
  // R5: the rest period never jumps straight back to a hold
  a_r5_rest_blocks_rx: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LO) |=> (state != S_HI));
endmodule

// File: rtl/hubled_ctrl.sv
module hubled_ctrl
  import hubled_pkg::*;
#(
  parameter int WIN_LOG2 = 16
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       sclk,
  output logic       latchStb,
  output hubStrobe_t stb
);
  logic                phase;
  logic [IDX_W-1:0]    bitIdx;
  logic [IDX_W-1:0]    nextIdx;
  logic [WIN_LOG2-1:0] winCnt;
  logic                lastBit;

  assign lastBit = (bitIdx == IDX_W'(FRAME_W - 1));
  assign nextIdx = lastBit ? '0 : bitIdx + 1'b1;

  always_comb begin
    stb.bitTick = phase;
    stb.load    = phase && lastBit;
    stb.shift   = phase && !lastBit;
    stb.winEnd  = phase && (&winCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      bitIdx   <= IDX_W'(FRAME_W - 1);
      winCnt   <= '0;
      latchStb <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        bitIdx   <= nextIdx;
        winCnt   <= winCnt + 1'b1;
        latchStb <= (nextIdx == IDX_W'(FRAME_W - 1));
      end
    end
  end

  assign sclk = phase;

  // R3: strobe spans exactly one bit period (two system cycles)
  a_r3_strobe_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchStb) |=> latchStb ##1 !latchStb);
endmodule

// File: rtl/hubled_dp.sv
module hubled_dp
  import hubled_pkg::*;
#(
  parameter int HI_MS    = 78,
  parameter int LO_MS    = 52,
  parameter int WIN_LOG2 = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  hubStrobe_t         stb,
  input  logic [FRAME_W-1:0] linkOk,
  input  logic [FRAME_W-1:0] rxAct,
  input  logic [FRAME_W-1:0] portPart,
  input  logic               mediumBusy,
  output logic               linkSer,
  output logic               partSer,
  output logic               trafSer
);
  localparam int WIDE = WIN_LOG2 + 11;
  localparam logic [WIN_LOG2:0] WIN_LEN = {1'b1, {WIN_LOG2{1'b0}}};

  function automatic int unsigned pctX8(input int idx);
    case (idx)
      0: return 8;
      1: return 50;
      2: return 100;
      3: return 200;
      4: return 300;
      5: return 400;
      6: return 500;
      default: return 700;
    endcase
  endfunction

  logic [FRAME_W-1:0] holdHi, linkBit, overThr, therm;
  logic [FRAME_W-1:0] linkSh, partSh, trafSh;
  logic [WIN_LOG2:0]  busyCnt, busyNext;

  for (genvar p = 0; p < FRAME_W; p++) begin : g_port
    hubled_stretch #(.HI_MS(HI_MS), .LO_MS(LO_MS)) u_stretch (
      .clk(clk), .rstN(rstN), .msTick(msTick),
      .rxAct(rxAct[p]), .hold(holdHi[p])
    );
    assign linkBit[p] = ~linkOk[p] | holdHi[p];
  end

  assign busyNext = busyCnt + {{WIN_LOG2{1'b0}}, mediumBusy};

  for (genvar t = 0; t < FRAME_W; t++) begin : g_thr
    assign overThr[t] = (WIDE'(busyNext) * WIDE'(800)) >
                        (WIDE'(WIN_LEN) * WIDE'(pctX8(t)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      therm   <= '1;
    end else if (stb.winEnd) begin
      busyCnt <= '0;
      therm   <= ~overThr;
    end else if (stb.bitTick) begin
      busyCnt <= busyNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkSh <= '0;
      partSh <= '0;
      trafSh <= '0;
    end else if (stb.load) begin
      linkSh <= linkBit;
      partSh <= ~portPart;
      trafSh <= therm;
    end else if (stb.shift) begin
      linkSh <= linkSh << 1;
      partSh <= partSh << 1;
      trafSh <= trafSh << 1;
    end
  end

  assign linkSer = linkSh[FRAME_W-1];
  assign partSer = partSh[FRAME_W-1];
  assign trafSer = trafSh[FRAME_W-1];

  // R7: active-low bar graph, lit bits contiguous from bit 0
  a_r7_thermo_shape: assert property (@(posedge clk) disable iff (!rstN)
    ((~therm) & ((~therm) + 1'b1)) == '0);
  // R8: busy count never passes the window length
  a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= WIN_LEN);
  // R6: a new partition frame reflects the flags at its load edge
  a_r6_part_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (partSh == ~$past(portPart)));
endmodule

// File: rtl/hubled_serializer.sv
module hubled_serializer
  import hubled_pkg::*;
#(
  parameter int HI_MS    = 78,
  parameter int LO_MS    = 52,
  parameter int WIN_LOG2 = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  logic [FRAME_W-1:0] linkOk,
  input  logic [FRAME_W-1:0] rxAct,
  input  logic [FRAME_W-1:0] portPart,
  input  logic               mediumBusy,
  output logic               sclk,
  output logic               latchStb,
  output logic               linkSer,
  output logic               partSer,
  output logic               trafSer
);
  hubStrobe_t stb;

  hubled_ctrl #(.WIN_LOG2(WIN_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .latchStb(latchStb), .stb(stb)
  );

  hubled_dp #(.HI_MS(HI_MS), .LO_MS(LO_MS), .WIN_LOG2(WIN_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .stb(stb),
    .linkOk(linkOk), .rxAct(rxAct), .portPart(portPart),
    .mediumBusy(mediumBusy),
    .linkSer(linkSer), .partSer(partSer), .trafSer(trafSer)
  );

  // R2: pins hold still unless sclk just fell
  a_r2_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !($past(sclk) && !sclk) |-> ($stable(linkSer) && $stable(partSer) && $stable(trafSer)));

  // R9: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r9_reset_quiet: assert ({sclk, latchStb, linkSer, partSer, trafSer} == 5'b0);
    end
  end
endmodule

// File: tb/hubled_serializer_tb.sv
module hubled_serializer_tb;
  localparam int HI_MS = 6;
  localparam int LO_MS = 4;
  localparam int WIN_LOG2 = 8;
  localparam int TICK_PER = 50;
  localparam int WIN_CLKS = 2 * (1 << WIN_LOG2);

  logic clk = 0, rstN = 0, msTick = 0, mediumBusy = 0;
  logic [7:0] linkOk = 8'hFF, rxAct = 8'h00, portPart = 8'h00;
  logic sclk, latchStb, linkSer, partSer, trafSer;

  hubled_serializer #(.HI_MS(HI_MS), .LO_MS(LO_MS), .WIN_LOG2(WIN_LOG2)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .linkOk(linkOk), .rxAct(rxAct),
    .portPart(portPart), .mediumBusy(mediumBusy), .sclk(sclk), .latchStb(latchStb),
    .linkSer(linkSer), .partSer(partSer), .trafSer(trafSer)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // {linkOk, portPart, expected link frame, expected partition frame}
  localparam logic [31:0] VEC [0:5] = '{
    32'hFF_00_00_FF, 32'h00_FF_FF_00, 32'hA5_5A_5A_A5,
    32'h7F_01_80_FE, 32'hFE_80_01_7F, 32'h3C_C3_C3_3C
  };

  // external receiver model and protocol monitors
  logic [7:0] shL = 0, shP = 0, shT = 0, latL = 0, latP = 0, latT = 0;
  logic prevSclk = 0;
  logic [2:0] prevPins = 0;
  logic [2:0] busyPh = 0;
  logic [3:0] busyK = 0;
  int frames = 0, risesInFrame = 0, r2Bad = 0, r3Bad = 0;

  always @(negedge clk) begin
    if ({linkSer, partSer, trafSer} != prevPins && !(prevSclk && !sclk)) r2Bad++;
    if (sclk && !prevSclk) begin
      shL = {shL[6:0], linkSer};
      shP = {shP[6:0], partSer};
      shT = {shT[6:0], trafSer};
      risesInFrame++;
      busyPh = busyPh + 3'd1;
      if (latchStb) begin
        if (frames > 0 && risesInFrame != 8) r3Bad++;
        latL = shL; latP = shP; latT = shT;
        frames++;
        risesInFrame = 0;
      end
    end
    mediumBusy = ({1'b0, busyPh} < busyK);
    prevSclk = sclk;
    prevPins = {linkSer, partSer, trafSer};
  end

  int tickCnt = 0;
  always @(negedge clk) begin
    tickCnt = (tickCnt == TICK_PER - 1) ? 0 : tickCnt + 1;
    msTick = (tickCnt == 0);
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    int target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    busyK = 8;
    repeat (6) @(negedge clk);
    // R9: outputs quiet in reset
    chk("R9 reset outputs", {3'b0, sclk, latchStb, linkSer, partSer, trafSer}, 8'h00);
    rstN = 1;
    // R8: code stays 8'hFF before the first window ends
    repeat (100) @(negedge clk);
    chk("R8 traffic before first window", latT, 8'hFF);
    repeat (WIN_CLKS + 100) @(negedge clk);
    chk("R8 traffic after full busy window", latT, 8'h00);

    // R1 R4 R6: table of link/partition patterns
    for (int v = 0; v < 6; v++) begin
      linkOk = VEC[v][31:24];
      portPart = VEC[v][23:16];
      waitFrames(3);
      chk("R1 R4 link frame", latL, VEC[v][15:8]);
      chk("R1 R6 partition frame", latP, VEC[v][7:0]);
    end

    // R7: busy share k/8 against the thresholds
    busyK = 0; repeat (3 * WIN_CLKS + 64) @(negedge clk);
    chk("R7 idle medium", latT, 8'hFF);
    busyK = 1; repeat (3 * WIN_CLKS + 64) @(negedge clk);
    chk("R7 12.5% not above 12.5", latT, 8'hFC);
    busyK = 4; repeat (3 * WIN_CLKS + 64) @(negedge clk);
    chk("R7 50% not above 50", latT, 8'hE0);
    busyK = 7; repeat (3 * WIN_CLKS + 64) @(negedge clk);
    chk("R7 87.5% not above 87.5", latT, 8'h80);
    busyK = 8; repeat (3 * WIN_CLKS + 64) @(negedge clk);
    chk("R7 full medium", latT, 8'h00);

    // R5: receive stretch on port 2
    linkOk = 8'hFF; portPart = 8'h00;
    waitFrames(3);
    chk("R4 all links pass", latL, 8'h00);
    rxAct = 8'h04; @(negedge clk); rxAct = 8'h00;
    repeat (99) @(negedge clk);
    chk("R5 hold high after packet", latL, 8'h04);
    repeat (209) @(negedge clk);
    rxAct = 8'h04; @(negedge clk); rxAct = 8'h00;
    repeat (50) @(negedge clk);
    chk("R5 packet in rest ignored", latL, 8'h00);
    repeat (240) @(negedge clk);
    chk("R5 idle after rest", latL, 8'h00);
    rxAct = 8'h04; @(negedge clk); rxAct = 8'h00;
    repeat (100) @(negedge clk);
    chk("R5 responds again after rest", latL, 8'h04);

    // R2 R3: protocol monitors over the whole run
    chk("R2 pin changes off falling edge", 8'(r2Bad), 8'd0);
    chk("R3 frame spacing violations", 8'(r3Bad), 8'd0);
    chk("R3 frames seen", 8'(frames > 100), 8'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule